// File: doc/BRIEF.md
# Two's-Complement ALU with Overflow-Safe Signed Compare

This block is a purely combinational arithmetic and logic unit for a datapath. It takes two operand words and a 3-bit operation code. It returns one result word and three flags: zero, carry-out and signed overflow. The supported operations are bitwise AND, bitwise OR, addition, subtraction and a signed "less than" compare. The compare returns 1 or 0 in the lowest result bit.

A single ripple adder serves addition, subtraction and the compare. For subtraction and compare, the second operand is complemented and the carry into bit 0 is set, so the adder forms the difference. Signed overflow comes from the two carries at the top bit position: the carry entering it and the carry leaving it. The compare does not trust the sign of the difference by itself. It flips that sign whenever the difference overflowed, so the answer stays correct when the operands are far apart, for example the most negative value against a positive value.

The word width is a parameter with a default of 32. The unit has no registers, so a consumer may sample its outputs in the same cycle as its inputs.

Top module: `alu_slt_core`

## Requirements
- R1: With op code 3'b000 the result is the bitwise AND of the operands, and carry-out and overflow are 0.
- R2: With op code 3'b001 the result is the bitwise OR of the operands, and carry-out and overflow are 0.
- R3: With op code 3'b010 the result is (a + b) modulo 2^WIDTH, and carry-out is bit WIDTH of the unbounded sum a + b.
- R4: With op code 3'b110 the result is (a - b) modulo 2^WIDTH, computed as a + ~b + 1. Carry-out is the carry leaving the top bit of that sum, which is 1 exactly when a >= b as unsigned numbers.
- R5: For op codes 3'b010, 3'b110 and 3'b111, the overflow flag is 1 exactly when the signed value of the true sum or difference lies outside the signed WIDTH-bit range. It equals the carry into the top bit XOR the carry out of the top bit.
- R6: With op code 3'b111, result bit 0 is 1 exactly when a < b as signed two's-complement numbers, including operand pairs whose difference overflows. Result bits WIDTH-1 down to 1 are 0. Carry-out and overflow are those of the subtraction a - b.
- R7: The zero flag is 1 exactly when every result bit is 0, for every op code.
- R8: The unused op codes 3'b011, 3'b100 and 3'b101 give an all-zero result, zero flag 1, and carry-out and overflow 0.
- R9: Overflow is never reported when the two words fed into the adder have different top bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (two's complement) |
| b_i | input | WIDTH | Second operand (two's complement) |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| carry_o | output | 1 | Carry leaving the top adder bit |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The case that is hardest to reach is a compare whose difference overflows. There the raw sign of a - b points the wrong way, and only the overflow correction gives the right answer. Such pairs make up a small share of random operand space. A second instance is therefore built at WIDTH=4 and driven through every operand pair under every op code, which covers each overflow pattern for every operation. The 32-bit instance then receives directed extremes (most negative against positives, -7 against 6, most positive against -1, equal operands) and a stream of pseudo-random words. All expected values come from signed and unsigned integer arithmetic in the bench.

// File: rtl/alu_slt_pkg.sv
package alu_slt_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // one-bit full adder: sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // one-bit full adder: carry output (majority)
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

  // signed less-than decision from a difference sign and its overflow
  function automatic logic signed_less(input logic diff_sign, input logic diff_ovf);
    return diff_sign ^ diff_ovf;
  endfunction

  // true when the op code routes through the inverted-operand adder path
  function automatic logic uses_subtract(input logic [2:0] op);
    return (op == OP_SUB) || (op == OP_SLT);
  endfunction

  // true when the op code uses the adder at all
  function automatic logic uses_adder(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT);
  endfunction

endpackage

// File: rtl/alu_slt_logic.sv
module alu_slt_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = x_i[i] & y_i[i];
    assign or_o[i]  = x_i[i] | y_i[i];
  end

endmodule

// File: rtl/alu_slt_adder.sv
module alu_slt_adder
  import alu_slt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_in_o,
  output logic             c_out_o
);

  logic [WIDTH:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sum_o[i]     = fa_sum(x_i[i], y_i[i], chain[i]);
    assign chain[i + 1] = fa_carry(x_i[i], y_i[i], chain[i]);
  end

  assign c_msb_in_o = chain[WIDTH-1];
  assign c_out_o    = chain[WIDTH];

endmodule

// File: rtl/alu_slt_compare.sv
module alu_slt_compare
  import alu_slt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             diff_sign_i,
  input  logic             diff_ovf_i,
  output logic [WIDTH-1:0] flag_word_o
);

  localparam int UPPER = WIDTH - 1;

  assign flag_word_o[0]       = signed_less(diff_sign_i, diff_ovf_i);
  assign flag_word_o[UPPER:1] = '0;

endmodule

// File: rtl/alu_slt_core.sv
module alu_slt_core
  import alu_slt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  // named internal events, exposed for the checker
  logic             sub_mode;
  logic [WIDTH-1:0] addend_b;
  logic [WIDTH-1:0] adder_sum;
  logic             c_msb_in;
  logic             c_out;
  logic             adder_ovf;
  logic [WIDTH-1:0] and_word;
  logic [WIDTH-1:0] or_word;
  logic [WIDTH-1:0] slt_word;

  assign sub_mode = uses_subtract(op_i);
  assign addend_b = sub_mode ? ~b_i : b_i;

  alu_slt_logic #(.WIDTH(WIDTH)) u_logic (
    .x_i  (a_i),
    .y_i  (b_i),
    .and_o(and_word),
    .or_o (or_word)
  );

  alu_slt_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i       (a_i),
    .y_i       (addend_b),
    .cin_i     (sub_mode),
    .sum_o     (adder_sum),
    .c_msb_in_o(c_msb_in),
    .c_out_o   (c_out)
  );

  assign adder_ovf = c_msb_in ^ c_out;

  alu_slt_compare #(.WIDTH(WIDTH)) u_cmp (
    .diff_sign_i(adder_sum[MSB]),
    .diff_ovf_i (adder_ovf),
    .flag_word_o(slt_word)
  );

  always_comb begin
    unique case (op_i)
      OP_AND:  result_o = and_word;
      OP_OR:   result_o = or_word;
      OP_ADD:  result_o = adder_sum;
      OP_SUB:  result_o = adder_sum;
      OP_SLT:  result_o = slt_word;
      default: result_o = '0;
    endcase
  end

  assign carry_o = uses_adder(op_i) & c_out;
  assign ovf_o   = uses_adder(op_i) & adder_ovf;
  assign zero_o  = ~(|result_o);

endmodule

// File: rtl/alu_slt_checker.sv
module alu_slt_checker #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic [W-1:0] addend_b,
  input logic         c_msb_in,
  input logic         c_out
);

  always_comb begin
    // R6: compare places only the signed decision in bit 0
    if (op_i == 3'b111) begin
      assert_slt_value_R6: assert (result_o == {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))});
    end
    // R7: zero flag tracks the result word
    assert_zero_flag_R7: assert (zero_o == (result_o == '0));
    // R9: opposite-sign addends never overflow
    if (a_i[W-1] != addend_b[W-1]) begin
      assert_no_overflow_R9: assert (!(c_msb_in ^ c_out));
    end
    // R3: addition result matches modular sum
    if (op_i == 3'b010) begin
      assert_add_value_R3: assert (result_o == W'(a_i + b_i));
    end
    // R1 / R2: logic ops leave carry and overflow low
    if (op_i == 3'b000 || op_i == 3'b001) begin
      assert_logic_flags_R1: assert (!carry_o && !ovf_o);
    end
    // R5: reported overflow implies same-sign addends with a sign flip in the result
    if (ovf_o && op_i != 3'b111) begin
      assert_ovf_sign_R5: assert ((a_i[W-1] == addend_b[W-1]) && (result_o[W-1] != a_i[W-1]));
    end
  end

endmodule

bind alu_slt_core alu_slt_checker #(.W(WIDTH)) u_checker (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .result_o(result_o),
  .zero_o  (zero_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o),
  .addend_b(addend_b),
  .c_msb_in(c_msb_in),
  .c_out   (c_out)
);

// File: tb/alu_slt_core_bench.sv
module alu_slt_core_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // wide instance
  logic [31:0] a32, b32, r32;
  logic [2:0]  op32;
  logic        z32, c32, v32;

  alu_slt_core #(.WIDTH(32)) u_alu_slt_core (
    .a_i(a32), .b_i(b32), .op_i(op32),
    .result_o(r32), .zero_o(z32), .carry_o(c32), .ovf_o(v32)
  );

  // narrow instance for exhaustive sweep
  logic [3:0] a4, b4, r4;
  logic [2:0] op4;
  logic       z4, c4, v4;

  alu_slt_core #(.WIDTH(4)) u_alu_slt_core_w4 (
    .a_i(a4), .b_i(b4), .op_i(op4),
    .result_o(r4), .zero_o(z4), .carry_o(c4), .ovf_o(v4)
  );

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint to_signed(input int w, input longint unsigned v);
    longint unsigned half = 64'd1 << (w - 1);
    return (v >= half) ? longint'(v) - longint'(64'd1 << w) : longint'(v);
  endfunction

  task automatic ref_model(input int w, input longint unsigned a, input longint unsigned b,
                           input logic [2:0] op, output longint unsigned r,
                           output bit z, output bit c, output bit v, output string req);
    longint unsigned mask = (64'd1 << w) - 1;
    longint sa = to_signed(w, a);
    longint sb = to_signed(w, b);
    longint smax = longint'(64'd1 << (w - 1)) - 1;
    longint smin = -longint'(64'd1 << (w - 1));
    longint s;
    r = 0; c = 0; v = 0;
    case (op)
      3'b000: begin r = a & b; req = "R1"; end
      3'b001: begin r = a | b; req = "R2"; end
      3'b010: begin
        r = (a + b) & mask; c = ((a + b) >> w) != 0;
        s = sa + sb; v = (s > smax) || (s < smin); req = "R3";
      end
      3'b110: begin
        r = (a - b) & mask; c = (a >= b);
        s = sa - sb; v = (s > smax) || (s < smin); req = "R4";
      end
      3'b111: begin
        r = (sa < sb) ? 1 : 0; c = (a >= b);
        s = sa - sb; v = (s > smax) || (s < smin); req = "R6";
      end
      default: begin r = 0; req = "R8"; end
    endcase
    z = (r == 0);
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
    longint unsigned r; bit z, c, v; string req;
    @(posedge clk);
    a4 = a; b4 = b; op4 = op;
    @(negedge clk);
    ref_model(4, a, b, op, r, z, c, v, req);
    chk(req, "w4 result", r4, r);
    chk("R7", "w4 zero", z4, z);
    chk((op == 3'b110 || op == 3'b111) ? "R4" : (op == 3'b010 ? "R3" : req), "w4 carry", c4, c);
    chk("R5", "w4 overflow", v4, v);
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    longint unsigned r; bit z, c, v; string req;
    @(posedge clk);
    a32 = a; b32 = b; op32 = op;
    @(negedge clk);
    ref_model(32, a, b, op, r, z, c, v, req);
    chk(req, "w32 result", r32, r);
    chk("R7", "w32 zero", z32, z);
    chk((op == 3'b110 || op == 3'b111) ? "R4" : (op == 3'b010 ? "R3" : req), "w32 carry", c32, c);
    chk("R5", "w32 overflow", v32, v);
  endtask

  task automatic all_ops32(input logic [31:0] a, input logic [31:0] b);
    for (int k = 0; k < 8; k++) run32(a, b, 3'(k));
  endtask

  initial begin
    longint unsigned rs = 64'h9E3779B97F4A7C15;
    a32 = '0; b32 = '0; op32 = 3'b000;
    a4 = '0; b4 = '0; op4 = 3'b000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // idle state: zero operands with AND give zero result and zero flag
    chk("R1", "initial result", r32, 0);
    chk("R7", "initial zero", z32, 1);

    // exhaustive 4-bit sweep, every op code including unused (R8)
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(4'(a), 4'(b), 3'(op));

    // R6: -7 vs 6 must report less
    run32(32'hFFFF_FFF9, 32'd6, 3'b111);
    chk("R6", "-7<6 bit", r32, 1);
    // R6 corners: most negative against positives, where a-b overflows
    all_ops32(32'h8000_0000, 32'd1);
    all_ops32(32'h8000_0000, 32'h7FFF_FFFF);
    all_ops32(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    all_ops32(32'h7FFF_FFFF, 32'h8000_0000);
    all_ops32(32'h8000_0000, 32'h8000_0000);
    all_ops32(32'h1234_5678, 32'h1234_5678);
    all_ops32(32'hFFFF_FFFF, 32'd1);
    all_ops32(32'h0, 32'h0);
    // R8: unused codes with nonzero operands
    run32(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b101);
    chk("R8", "unused code result", r32, 0);

    for (int i = 0; i < 200; i++) begin
      logic [31:0] ra, rb;
      rs ^= rs << 13; rs ^= rs >> 7; rs ^= rs << 17;
      ra = rs[31:0]; rb = rs[63:32];
      if (i % 4 == 0) rb = {ra[31], rb[30:0]};
      all_ops32(ra, rb);
    end
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule